// File: doc/BRIEF.md
# Event Counter Bank with Overflow Interrupt

This block is a bank of eight counter slots for measuring traffic on a PCIe controller. Each slot holds two 64-bit counters and one 64-bit control word. The main counter advances on the slot's event pulse and the extended counter advances on the slot's qualifier input. A slot counts only while its own enable bit and the bank-wide enable bit are both set. Software reaches every register through a 32-bit word port. A 64-bit register is split into a low word at its base offset and a high word at the base plus four.

To measure, software does the following for each slot:

1. Writes the control word.
2. Loads both counters through the port, usually with only bit 63 set.
3. Clears the slot's interrupt mask.
4. Sets the bank enable.

When a counter steps from all ones to zero, the slot latches an interrupt status bit. That bit is cleared by writing a one to it. The interrupt output is raised for every latched status bit whose mask is clear. Three read-only words carry values fixed at integration time: a requester-ID range, a version number and a location identifier.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, control words and status bits read 0. Every mask bit reads 1, the bank enable reads 0 and `irq` is 0.
- R2: The register map is laid out as follows.
  - Bank enable is bit 0 at 0x000.
  - Control words of slot i are at 0x010+8i.
  - Main counters are at 0x090+8i.
  - Extended counters are at 0x110+8i.
  - Status of slot i is bit 0 at 0x150+8i and its mask is bit 0 at 0x154+8i.
  - The 64-bit registers take the low word at the base and the high word at base+4.
  - All control bits written are read back, bit 22 excepted.
- R3: While the bank enable (bit 0 at 0x000) is 0, no counter of any slot changes except by a port write.
- R4: When the bank enable and a slot's control bit 20 are both set, that slot's main counter adds one for each cycle with its event pulse high. Its extended counter adds one for each cycle with its qualifier high. A slot with bit 20 clear does not count.
- R5: Writing the low control word of a slot with bit 22 set clears both of that slot's counters in the next cycle. Bit 22 always reads back as 0.
- R6: A port write to one half of a counter replaces that half and keeps the other half. If an increment falls in the same cycle, the write wins and no increment happens.
- R7: A counter stepping from all ones to zero sets that slot's status bit. The status bit stays set until software clears it.
- R8: Writing 1 to bit 0 of a status word clears it, and writing 0 leaves it set. If a wrap and a clear fall in the same cycle, the bit stays set.
- R9: `irq` is high exactly when some slot has its status set and its mask clear.
- R10: The word at 0xFE0 returns the minimum requester ID in bits 15:0 and the maximum in bits 31:16. The word at 0xFE4 returns the version. The word at 0xFE8 returns the core id in bits 15:0 and the cluster id in bits 31:16. Writes to these three words have no effect. Unmapped or misaligned addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 12 | Byte address of the register word |
| reg_wr | input | 1 | Write strobe, applied at the rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, available in the same cycle |
| evt_pulse | input | NUM_SLOTS | Per-slot event pulse that drives the main counter |
| evt_qual | input | NUM_SLOTS | Per-slot qualifier that drives the extended counter |
| irq | output | 1 | Aggregated overflow interrupt |

## Verification
A counter wrap cannot be reached by counting from zero, because that would take 2^64 events. The bench therefore loads each counter through its two halves to one or two steps below the wrap, then applies single pulses and watches the status bit and `irq`. It also holds a write to the same counter in the same cycle as a pulse, to show that the write wins. The hardest case is a wrap that coincides with a software clear of the status bit. The bench reaches it by preloading a counter to all ones and then issuing the status-clear write while that slot's pulse is high.

// File: rtl/pcb_pkg.sv
`timescale 1ns/1ps
package pcb_pkg;
    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned REG_W  = 64;
    localparam int unsigned STRIDE = 8;

    localparam logic [ADDR_W-1:0] OFS_GLOBAL = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_EVCTL  = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_MAIN   = 12'h090;
    localparam logic [ADDR_W-1:0] OFS_EXT    = 12'h110;
    localparam logic [ADDR_W-1:0] OFS_IRQ    = 12'h150;
    localparam logic [ADDR_W-1:0] OFS_RID    = 12'hFE0;
    localparam logic [ADDR_W-1:0] OFS_VER    = 12'hFE4;
    localparam logic [ADDR_W-1:0] OFS_INFO   = 12'hFE8;

    localparam int unsigned BIT_EN  = 20;
    localparam int unsigned BIT_CLR = 22;

    typedef enum logic [3:0] {
        RK_NONE, RK_GLOBAL, RK_EVCTL, RK_MAIN, RK_EXT,
        RK_ISTAT, RK_IMASK, RK_RID, RK_VER, RK_INFO
    } reg_kind_e;

    function automatic logic [REG_W-1:0] put_half(input logic [REG_W-1:0] old,
                                                  input logic hi,
                                                  input logic [WORD_W-1:0] d);
        logic [REG_W-1:0] r;
        r = old;
        if (hi) r[REG_W-1:WORD_W] = d;
        else    r[WORD_W-1:0]     = d;
        return r;
    endfunction
endpackage

// File: rtl/pcb_decode.sv
`timescale 1ns/1ps
module pcb_decode
    import pcb_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output logic              hi
);
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(STRIDE * NUM_SLOTS);

    function automatic logic in_arr(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
        return (a >= base) && ((a - base) < SPAN);
    endfunction

    logic [ADDR_W-1:0] rel;

    always_comb begin
        kind = RK_NONE;
        rel  = '0;
        hi   = addr[2];
        if (addr[1:0] == 2'b00) begin
            if (addr == OFS_GLOBAL) begin
                kind = RK_GLOBAL;
            end else if (in_arr(addr, OFS_EVCTL)) begin
                kind = RK_EVCTL;
                rel  = addr - OFS_EVCTL;
            end else if (in_arr(addr, OFS_MAIN)) begin
                kind = RK_MAIN;
                rel  = addr - OFS_MAIN;
            end else if (in_arr(addr, OFS_EXT)) begin
                kind = RK_EXT;
                rel  = addr - OFS_EXT;
            end else if (in_arr(addr, OFS_IRQ)) begin
                kind = addr[2] ? RK_IMASK : RK_ISTAT;
                rel  = addr - OFS_IRQ;
            end else if (addr == OFS_RID) begin
                kind = RK_RID;
            end else if (addr == OFS_VER) begin
                kind = RK_VER;
            end else if (addr == OFS_INFO) begin
                kind = RK_INFO;
            end
        end
        idx = IDX_W'(rel >> 3);
    end
endmodule

// File: rtl/pcb_slot.sv
`timescale 1ns/1ps
module pcb_slot
    import pcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              evt_pulse,
    input  logic              evt_qual,
    input  logic              wr_en,
    input  reg_kind_e         wr_kind,
    input  logic              wr_hi,
    input  logic [WORD_W-1:0] wr_data,
    output logic [REG_W-1:0]  ctrl_o,
    output logic [REG_W-1:0]  main_o,
    output logic [REG_W-1:0]  ext_o,
    output logic              stat_o,
    output logic              mask_o
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] main;
        logic [REG_W-1:0] ext;
        logic             stat;
        logic             mask;
    } slot_t;

    slot_t s_d, s_q;
    logic  counting, clr_cnt, wrap_main, wrap_ext;

    always_comb begin
        s_d       = s_q;
        wrap_main = 1'b0;
        wrap_ext  = 1'b0;
        counting  = glb_en && s_q.ctrl[BIT_EN];
        clr_cnt   = wr_en && (wr_kind == RK_EVCTL) && !wr_hi && wr_data[BIT_CLR];

        if (wr_en && (wr_kind == RK_EVCTL)) begin
            s_d.ctrl          = put_half(s_q.ctrl, wr_hi, wr_data);
            s_d.ctrl[BIT_CLR] = 1'b0;
        end

        if (wr_en && (wr_kind == RK_MAIN)) begin
            s_d.main = put_half(s_q.main, wr_hi, wr_data);
        end else if (clr_cnt) begin
            s_d.main = '0;
        end else if (counting && evt_pulse) begin
            s_d.main  = s_q.main + REG_W'(1);
            wrap_main = &s_q.main;
        end

        if (wr_en && (wr_kind == RK_EXT)) begin
            s_d.ext = put_half(s_q.ext, wr_hi, wr_data);
        end else if (clr_cnt) begin
            s_d.ext = '0;
        end else if (counting && evt_qual) begin
            s_d.ext  = s_q.ext + REG_W'(1);
            wrap_ext = &s_q.ext;
        end

        if (wr_en && (wr_kind == RK_IMASK)) s_d.mask = wr_data[0];

        if (wrap_main || wrap_ext)
            s_d.stat = 1'b1;
        else if (wr_en && (wr_kind == RK_ISTAT) && wr_data[0])
            s_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ctrl: '0, main: '0, ext: '0, stat: 1'b0, mask: 1'b1};
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign main_o = s_q.main;
    assign ext_o  = s_q.ext;
    assign stat_o = s_q.stat;
    assign mask_o = s_q.mask;
endmodule

// File: rtl/perf_counter_bank.sv
`timescale 1ns/1ps
module perf_counter_bank
    import pcb_pkg::*;
#(
    parameter int unsigned NUM_SLOTS  = 8,
    parameter logic [31:0] VERSION_ID = 32'h0000_0001,
    parameter logic [15:0] RID_MIN    = 16'h0000,
    parameter logic [15:0] RID_MAX    = 16'h00FF,
    parameter logic [15:0] CORE_ID    = 16'h0000,
    parameter logic [15:0] CLUSTER_ID = 16'h0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    input  logic [NUM_SLOTS-1:0] evt_pulse,
    input  logic [NUM_SLOTS-1:0] evt_qual,
    output logic                 irq
);
    localparam int unsigned IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        logic en;
    } glb_t;

    glb_t glb_d, glb_q;
    logic glb_en;

    reg_kind_e        dec_kind;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_hi;

    logic [NUM_SLOTS-1:0][REG_W-1:0] ctrl_v, main_v, ext_v;
    logic [NUM_SLOTS-1:0]            stat_v, mask_v;

    pcb_decode #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_decode (
        .addr (reg_addr),
        .kind (dec_kind),
        .idx  (dec_idx),
        .hi   (dec_hi)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        pcb_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .glb_en    (glb_en),
            .evt_pulse (evt_pulse[g]),
            .evt_qual  (evt_qual[g]),
            .wr_en     (reg_wr && (dec_idx == IDX_W'(g))),
            .wr_kind   (dec_kind),
            .wr_hi     (dec_hi),
            .wr_data   (reg_wdata),
            .ctrl_o    (ctrl_v[g]),
            .main_o    (main_v[g]),
            .ext_o     (ext_v[g]),
            .stat_o    (stat_v[g]),
            .mask_o    (mask_v[g])
        );
    end

    always_comb begin
        glb_d = glb_q;
        if (reg_wr && (dec_kind == RK_GLOBAL)) glb_d.en = reg_wdata[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) glb_q <= '0;
        else        glb_q <= glb_d;
    end

    assign glb_en = glb_q.en;

    always_comb begin
        reg_rdata = '0;
        case (dec_kind)
            RK_GLOBAL: reg_rdata = {31'b0, glb_q.en};
            RK_EVCTL:  reg_rdata = dec_hi ? ctrl_v[dec_idx][REG_W-1:WORD_W] : ctrl_v[dec_idx][WORD_W-1:0];
            RK_MAIN:   reg_rdata = dec_hi ? main_v[dec_idx][REG_W-1:WORD_W] : main_v[dec_idx][WORD_W-1:0];
            RK_EXT:    reg_rdata = dec_hi ? ext_v[dec_idx][REG_W-1:WORD_W]  : ext_v[dec_idx][WORD_W-1:0];
            RK_ISTAT:  reg_rdata = {31'b0, stat_v[dec_idx]};
            RK_IMASK:  reg_rdata = {31'b0, mask_v[dec_idx]};
            RK_RID:    reg_rdata = {RID_MAX, RID_MIN};
            RK_VER:    reg_rdata = VERSION_ID;
            RK_INFO:   reg_rdata = {CLUSTER_ID, CORE_ID};
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = |(stat_v & ~mask_v);
endmodule

// File: rtl/pcb_checker.sv
`timescale 1ns/1ps
module pcb_checker
    import pcb_pkg::*;
#(
    parameter int unsigned NUM_SLOTS = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic                            reg_wr,
    input logic [WORD_W-1:0]               reg_wdata,
    input logic                            glb_en,
    input logic [NUM_SLOTS-1:0][REG_W-1:0] main_v,
    input logic [NUM_SLOTS-1:0][REG_W-1:0] ext_v,
    input logic [NUM_SLOTS-1:0]            stat_v,
    input logic [NUM_SLOTS-1:0]            mask_v,
    input logic                            irq
);
    // R3: with the bank disabled and no port write, counters hold
    a_r3_hold_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_en && !reg_wr) |=> ($stable(main_v) && $stable(ext_v)));

    // R9: no status set, or every slot masked, means no interrupt
    a_r9_no_irq_without_status: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_v == '0) |-> !irq);
    a_r9_no_irq_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask_v) |-> !irq);

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_chk
        localparam logic [ADDR_W-1:0] A_CTL  = OFS_EVCTL + ADDR_W'(STRIDE * i);
        localparam logic [ADDR_W-1:0] A_MAIN = OFS_MAIN + ADDR_W'(STRIDE * i);

        // R5: counter-clear bit empties both counters of the slot
        a_r5_clear_counters: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_CTL && reg_wdata[BIT_CLR]) |=> (main_v[i] == '0 && ext_v[i] == '0));

        // R6: a low-half counter write lands even if a pulse came too
        a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == A_MAIN) |=> (main_v[i][WORD_W-1:0] == $past(reg_wdata)));

        // R7: status only rises when a counter has just reached zero
        a_r7_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_v[i]) |-> (main_v[i] == '0 || ext_v[i] == '0));

        // R8: status only falls after a port write
        a_r8_fall_on_write: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat_v[i]) |-> $past(reg_wr));
    end
endmodule

bind perf_counter_bank pcb_checker #(.NUM_SLOTS(NUM_SLOTS)) i_pcb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .glb_en    (glb_en),
    .main_v    (main_v),
    .ext_v     (ext_v),
    .stat_v    (stat_v),
    .mask_v    (mask_v),
    .irq       (irq)
);

// File: tb/test_perf_counter_bank.sv
`timescale 1ns/1ps
module test_perf_counter_bank;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] evt_pulse = '0;
    logic [N-1:0] evt_qual = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_main [N];
    logic [63:0] exp_ext  [N];

    always #2.5 clk = ~clk;

    perf_counter_bank #(
        .NUM_SLOTS(N), .VERSION_ID(32'h0002_0013), .RID_MIN(16'h0008),
        .RID_MAX(16'h0030), .CORE_ID(16'h0003), .CLUSTER_ID(16'h0005)
    ) i_perf_counter_bank (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
        .evt_qual(evt_qual), .irq(irq)
    );

    function automatic logic [11:0] a_ctl(int i);  return 12'(12'h010 + 8 * i); endfunction
    function automatic logic [11:0] a_main(int i); return 12'(12'h090 + 8 * i); endfunction
    function automatic logic [11:0] a_ext(int i);  return 12'(12'h110 + 8 * i); endfunction
    function automatic logic [11:0] a_stat(int i); return 12'(12'h150 + 8 * i); endfunction
    function automatic logic [11:0] a_mask(int i); return 12'(12'h154 + 8 * i); endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_with(input logic [11:0] a, input logic [31:0] d,
                           input logic [N-1:0] p, input logic [N-1:0] q);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; evt_pulse = p; evt_qual = q;
        @(negedge clk);
        reg_wr = 1'b0; evt_pulse = '0; evt_qual = '0;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_with(a, d, '0, '0);
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic rd64(input logic [11:0] a, output logic [63:0] v);
        logic [31:0] lo, hi;
        rd(a, lo);
        rd(12'(a + 4), hi);
        v = {hi, lo};
    endtask

    task automatic pulse_once(input logic [N-1:0] p, input logic [N-1:0] q);
        @(negedge clk);
        evt_pulse = p; evt_qual = q;
        @(negedge clk);
        evt_pulse = '0; evt_qual = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got no completion expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] v64;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R1: reset state across every slot
        for (int i = 0; i < N; i++) begin
            rd64(a_main(i), v64); check("R1 main reset", v64, 64'h0);
            rd64(a_ext(i), v64);  check("R1 ext reset", v64, 64'h0);
            rd64(a_ctl(i), v64);  check("R1 ctrl reset", v64, 64'h0);
            rd(a_stat(i), v);     check("R1 status reset", {32'h0, v}, 64'h0);
            rd(a_mask(i), v);     check("R1 mask reset", {32'h0, v}, 64'h1);
        end
        rd(12'h000, v); check("R1 enable reset", {32'h0, v}, 64'h0);
        check("R1 irq reset", {63'h0, irq}, 64'h0);

        // R2: control high half stores bit 34 (high word bit 2)
        wr(12'h014, 32'h0000_0004);
        rd64(a_ctl(0), v64); check("R2 ctrl high half", v64, 64'h4_0000_0000);

        // R4: enable even slots only, then sweep pulse patterns
        for (int i = 0; i < N; i += 2) wr(a_ctl(i), 32'h0010_0000);
        wr(12'h000, 32'h1);
        rd(12'h000, v); check("R2 enable readback", {32'h0, v}, 64'h1);
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            for (int i = 0; i < N; i++) begin
                evt_pulse[i] = (c % (i + 1)) == 0;
                evt_qual[i]  = (c % (i + 2)) == 0;
            end
        end
        @(negedge clk);
        evt_pulse = '0; evt_qual = '0;
        for (int i = 0; i < N; i++) begin
            exp_main[i] = (i % 2 == 0) ? 64'(39 / (i + 1) + 1) : 64'h0;
            exp_ext[i]  = (i % 2 == 0) ? 64'(39 / (i + 2) + 1) : 64'h0;
            rd64(a_main(i), v64); check("R4 main count", v64, exp_main[i]);
            rd64(a_ext(i), v64);  check("R4 ext count", v64, exp_ext[i]);
        end

        // R3: bank disabled, pulses ignored
        wr(12'h000, 32'h0);
        for (int k = 0; k < 10; k++) pulse_once('1, '1);
        for (int i = 0; i < N; i++) begin
            rd64(a_main(i), v64); check("R3 main held", v64, exp_main[i]);
            rd64(a_ext(i), v64);  check("R3 ext held", v64, exp_ext[i]);
        end
        wr(12'h000, 32'h1);

        // R5: clear bit empties slot 0, reads back 0
        wr(a_ctl(0), 32'h0050_0000);
        rd64(a_main(0), v64); check("R5 main cleared", v64, 64'h0);
        rd64(a_ext(0), v64);  check("R5 ext cleared", v64, 64'h0);
        rd(a_ctl(0), v);      check("R5 clear bit reads 0", {32'h0, v}, 64'h0010_0000);
        rd64(a_main(2), v64); check("R5 other slot kept", v64, exp_main[2]);

        // R6: half writes win over same-cycle pulses on slot 4
        wr_with(a_main(4), 32'hFFFF_FFFE, 8'h10, 8'h00);
        rd64(a_main(4), v64); check("R6 low half write", v64, {32'h0, 32'hFFFF_FFFE});
        wr_with(12'(a_main(4) + 4), 32'hFFFF_FFFF, 8'h10, 8'h00);
        rd64(a_main(4), v64); check("R6 high half write", v64, 64'hFFFF_FFFF_FFFF_FFFE);

        // R7: step to all ones, then wrap
        pulse_once(8'h10, 8'h00);
        rd64(a_main(4), v64); check("R7 all ones", v64, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(a_stat(4), v);     check("R7 no status yet", {32'h0, v}, 64'h0);
        pulse_once(8'h10, 8'h00);
        rd64(a_main(4), v64); check("R7 wrapped", v64, 64'h0);
        rd(a_stat(4), v);     check("R7 status set", {32'h0, v}, 64'h1);
        check("R9 masked no irq", {63'h0, irq}, 64'h0);

        // R9: unmask raises irq
        wr(a_mask(4), 32'h0);
        check("R9 irq raised", {63'h0, irq}, 64'h1);

        // R8: writing 0 keeps, writing 1 clears
        wr(a_stat(4), 32'h0);
        rd(a_stat(4), v); check("R8 zero write keeps", {32'h0, v}, 64'h1);
        wr(a_stat(4), 32'h1);
        rd(a_stat(4), v); check("R8 one write clears", {32'h0, v}, 64'h0);
        check("R9 irq dropped", {63'h0, irq}, 64'h0);

        // R7: extended counter wrap on slot 6, still masked
        wr(a_ext(6), 32'hFFFF_FFFF);
        wr(12'(a_ext(6) + 4), 32'hFFFF_FFFF);
        pulse_once(8'h00, 8'h40);
        rd64(a_ext(6), v64); check("R7 ext wrapped", v64, 64'h0);
        rd(a_stat(6), v);    check("R7 ext status", {32'h0, v}, 64'h1);
        check("R9 slot6 masked", {63'h0, irq}, 64'h0);

        // R8: wrap coinciding with clear keeps status
        wr(a_main(6), 32'hFFFF_FFFF);
        wr(12'(a_main(6) + 4), 32'hFFFF_FFFF);
        wr_with(a_stat(6), 32'h1, 8'h40, 8'h00);
        rd64(a_main(6), v64); check("R8 collide wrap", v64, 64'h0);
        rd(a_stat(6), v);     check("R8 set beats clear", {32'h0, v}, 64'h1);
        wr(a_stat(6), 32'h1);
        rd(a_stat(6), v);     check("R8 later clear", {32'h0, v}, 64'h0);

        // R10: identification words, read-only, unmapped
        rd(12'hFE0, v); check("R10 rid range", {32'h0, v}, 64'h0030_0008);
        rd(12'hFE4, v); check("R10 version", {32'h0, v}, 64'h0002_0013);
        rd(12'hFE8, v); check("R10 info", {32'h0, v}, 64'h0005_0003);
        wr(12'hFE4, 32'hDEAD_BEEF);
        rd(12'hFE4, v); check("R10 version read-only", {32'h0, v}, 64'h0002_0013);
        wr(12'h800, 32'hFFFF_FFFF);
        rd(12'h800, v); check("R10 unmapped reads 0", {32'h0, v}, 64'h0);
        rd(12'h092, v); check("R10 misaligned reads 0", {32'h0, v}, 64'h0);
        rd64(a_main(2), v64); check("R10 unmapped write no effect", v64, exp_main[2]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule